// File: doc/BRIEF.md
# Binary Image Run-Length Coder

This block compresses a stream of binary image pixels. Each pixel arrives as one byte that is either all ones or all zeros, qualified by a valid strobe. In coding mode the block merges each stretch of equal consecutive pixels into a single code byte. The top bit of that byte holds the pixel value and the low seven bits hold how many pixels the stretch contained. A frame-start strobe on the first pixel of each frame closes whatever stretch is still open. The code for the stretch that begins on that pixel carries a frame-start flag on the output.

A mode bit, sampled only on frame-start pixels, selects between coding and a transparent mode. In transparent mode every valid input byte reappears on the output together with its frame-start flag. The consumer takes one byte per valid output cycle and cannot stall the block.

Top module: `rlc_bin_coder`

## Requirements
- R1: While reset is asserted, and afterwards until the first valid pixel has been sampled, `code_vld_o` and `fsync_o` are 0.
- R2: A code byte holds the run's pixel value in bit 7 (1 for 8'hFF, 0 for 8'h00) and the run length as unsigned binary in bits 6:0.
- R3: In coding mode, a valid pixel whose value differs from the open run ends that run. Its code is valid for exactly one cycle, registered on the same clock edge that samples the terminating pixel. The new pixel opens a run of length 1.
- R4: When a run reaches 127 pixels, its code (length 127) is emitted on the edge that samples the 127th pixel, and the next equal pixel opens a new run. A code never carries a length of 0.
- R5: A valid pixel with `fsync_i` high ends any open run and emits its code, even when the value is unchanged. The pixel itself starts a new run, so runs never span two frames.
- R6: `fsync_o` is 1 exactly with the code of a run that started on a frame-start pixel, or with a transparent byte whose input carried frame start. Otherwise it is 0.
- R7: In transparent mode each valid input byte appears on `code_o` with `code_vld_o` high two clock edges after it is sampled, and its frame-start bit is forwarded on `fsync_o`.
- R8: The mode is taken from `en_i` (1 = coding, 0 = transparent) only on a valid frame-start pixel and holds for the rest of the frame. Pixels before the first frame start after reset are handled in transparent mode.
- R9: Cycles with `pix_vld_i` low have no effect: they neither end nor extend a run, and produce no output.
- R10: At most one byte is presented per cycle. The closing code of a coded frame and the bytes of a following transparent frame never collide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | Pixel byte, 8'hFF or 8'h00 |
| pix_vld_i | input | 1 | Pixel byte valid |
| fsync_i | input | 1 | Current pixel is the first of a frame |
| en_i | input | 1 | Mode select sampled at frame start: 1 code, 0 transparent |
| code_o | output | 8 | Code byte or transparent byte |
| code_vld_o | output | 1 | Output byte valid, one cycle per byte |
| fsync_o | output | 1 | Output byte starts a frame |

## Verification
Assertions check on every cycle a set of invariants. No output appears before the first pixel after reset. A code is never reported with zero length. `fsync_o` is only raised with a valid byte. Coded and transparent outputs never coincide. A code only follows a sampled pixel, and a transparent byte only follows a pixel two edges earlier. Exact code values, the 127 split, frame-boundary flushes, the timing of mode changes, and the handover between transparent and coded frames can only be shown by the bench's scenarios. The bench compares every output cycle against a model built from the requirements.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int unsigned PIX_W   = 8;
  localparam int unsigned CNT_W   = PIX_W - 1;
  localparam int unsigned MAX_RUN = (1 << CNT_W) - 1;
  localparam int unsigned BYP_LAT = 2;

  typedef struct packed {
    logic             vld;
    logic             fs;
    logic [PIX_W-1:0] data;
  } beat_t;
endpackage

// File: rtl/rlc_mode_ctl.sv
module rlc_mode_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pix_vld_i,
  input  logic fsync_i,
  input  logic en_i,
  output logic code_mode_o
);
  logic mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   mode_q <= 1'b0;
    else if (pix_vld_i && fsync_i) mode_q <= en_i;
  end

  // frame-start pixel already follows the new mode
  assign code_mode_o = fsync_i ? en_i : mode_q;
endmodule

// File: rtl/rlc_run_cnt.sv
module rlc_run_cnt
  import rlc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pix_vld_i,
  input  logic  fsync_i,
  input  logic  pix_bit_i,
  input  logic  code_mode_i,
  output beat_t run_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RUN);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             open_q, open_d;
  logic             val_q, val_d;
  logic             first_q, first_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             flush, differ, full, emit, coding;
  beat_t            out_d, out_q;

  assign coding  = pix_vld_i && code_mode_i;
  assign cnt_inc = cnt_q + CNT_ONE;
  assign flush   = pix_vld_i && fsync_i && open_q;
  assign differ  = coding && open_q && !fsync_i && (pix_bit_i != val_q);
  assign full    = coding && open_q && !fsync_i && !differ && (cnt_inc == CNT_MAX);
  assign emit    = flush || differ || full;

  always_comb begin
    open_d  = open_q;
    val_d   = val_q;
    first_d = first_q;
    cnt_d   = cnt_q;
    if (pix_vld_i) begin
      if (!code_mode_i) begin
        open_d = 1'b0;
      end else if (!open_q || fsync_i || differ) begin
        open_d  = 1'b1;
        val_d   = pix_bit_i;
        first_d = fsync_i;
        cnt_d   = CNT_ONE;
      end else if (full) begin
        open_d = 1'b0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_comb begin
    out_d      = '0;
    out_d.vld  = emit;
    out_d.fs   = emit && first_q;
    out_d.data = {val_q, full ? CNT_MAX : cnt_q};
    if (!emit) out_d.data = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      val_q   <= 1'b0;
      first_q <= 1'b0;
      cnt_q   <= '0;
      out_q   <= '0;
    end else begin
      open_q  <= open_d;
      val_q   <= val_d;
      first_q <= first_d;
      cnt_q   <= cnt_d;
      out_q   <= out_d;
    end
  end

  assign run_o = out_q;
endmodule

// File: rtl/rlc_bypass.sv
module rlc_bypass
  import rlc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_vld_i,
  input  logic             fsync_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             code_mode_i,
  output beat_t            byp_o
);
  beat_t stg_q [BYP_LAT];
  beat_t in_beat;

  always_comb begin
    in_beat      = '0;
    in_beat.vld  = pix_vld_i && !code_mode_i;
    in_beat.fs   = pix_vld_i && !code_mode_i && fsync_i;
    in_beat.data = in_beat.vld ? pix_i : '0;
  end

  // fixed depth keeps transparent bytes clear of the closing code slot
  for (genvar i = 0; i < BYP_LAT; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[i] <= '0;
      else if (i == 0) stg_q[i] <= in_beat;
      else             stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign byp_o = stg_q[BYP_LAT-1];
endmodule

// File: rtl/rlc_bin_coder.sv
module rlc_bin_coder
  import rlc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_vld_i,
  input  logic             fsync_i,
  input  logic             en_i,
  output logic [PIX_W-1:0] code_o,
  output logic             code_vld_o,
  output logic             fsync_o
);
  logic  code_mode;
  beat_t run_beat, byp_beat;
  logic  run_vld, byp_vld;

  rlc_mode_ctl u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pix_vld_i  (pix_vld_i),
    .fsync_i    (fsync_i),
    .en_i       (en_i),
    .code_mode_o(code_mode)
  );

  rlc_run_cnt u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pix_vld_i  (pix_vld_i),
    .fsync_i    (fsync_i),
    .pix_bit_i  (pix_i[PIX_W-1]),
    .code_mode_i(code_mode),
    .run_o      (run_beat)
  );

  rlc_bypass u_byp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pix_vld_i  (pix_vld_i),
    .fsync_i    (fsync_i),
    .pix_i      (pix_i),
    .code_mode_i(code_mode),
    .byp_o      (byp_beat)
  );

  assign run_vld    = run_beat.vld;
  assign byp_vld    = byp_beat.vld;
  assign code_vld_o = run_vld || byp_vld;
  assign code_o     = run_vld ? run_beat.data : byp_beat.data;
  assign fsync_o    = run_vld ? run_beat.fs : byp_beat.fs;
endmodule

// File: rtl/rlc_bin_coder_chk.sv
module rlc_bin_coder_chk
  import rlc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_vld_i,
  input logic             code_vld_o,
  input logic             fsync_o,
  input logic [CNT_W-1:0] code_cnt,
  input logic             run_vld,
  input logic             byp_vld
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= 1'b0;
    else if (pix_vld_i) seen_q <= 1'b1;
  end

  // R1
  no_early_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !code_vld_o);

  // R4
  nonzero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_vld |-> code_cnt != '0);

  // R6
  fsync_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> code_vld_o);

  // R10
  single_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_vld && byp_vld));

  // R9
  run_after_pixel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_vld |-> $past(pix_vld_i));

  // R7
  bypass_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_vld |-> $past(pix_vld_i, 2));
endmodule

bind rlc_bin_coder rlc_bin_coder_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pix_vld_i (pix_vld_i),
  .code_vld_o(code_vld_o),
  .fsync_o   (fsync_o),
  .code_cnt  (code_o[rlc_pkg::CNT_W-1:0]),
  .run_vld   (run_vld),
  .byp_vld   (byp_vld)
);

// File: tb/rlc_bin_coder_test.sv
module rlc_bin_coder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pix_i = '0;
  logic       pix_vld_i = 1'b0;
  logic       fsync_i = 1'b0;
  logic       en_i = 1'b0;
  logic [7:0] code_o;
  logic       code_vld_o;
  logic       fsync_o;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    mon_on = 1'b0;
  bit    any_pix = 1'b0;
  string scen = "reset";

  logic [7:0] exp_code [int];
  bit         exp_fs   [int];
  string      exp_req  [int];

  // reference state
  bit m_open = 0, m_val = 0, m_first = 0, m_mode = 0;
  int m_cnt = 0;

  rlc_bin_coder uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] cycle %0d: actual %0h expected %0h", req, scen, cyc, act, exp);
    end
  endtask

  function automatic void emit(input int c, input logic [7:0] b, input bit fs, input string r);
    exp_code[c] = b;
    exp_fs[c]   = fs;
    exp_req[c]  = r;
  endfunction

  function automatic void model(input bit one, input bit fs, input bit en, input int n);
    bit mode;
    mode = fs ? en : m_mode;
    if (fs) m_mode = en;
    if (fs && m_open) begin
      emit(n, {m_val, 7'(m_cnt)}, m_first, "R5");
      m_open = 0;
    end
    if (!mode) begin
      emit(n + 1, one ? 8'hFF : 8'h00, fs, "R7");
      return;
    end
    if (m_open && one != m_val) begin
      emit(n, {m_val, 7'(m_cnt)}, m_first, "R3");
      m_open = 0;
    end
    if (m_open) begin
      m_cnt++;
      if (m_cnt == 127) begin
        emit(n, {m_val, 7'd127}, m_first, "R4");
        m_open = 0;
      end
    end else begin
      m_open = 1; m_val = one; m_cnt = 1; m_first = fs;
    end
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic px(input bit one, input bit fs, input bit en);
    pix_i = one ? 8'hFF : 8'h00;
    pix_vld_i = 1'b1;
    fsync_i = fs;
    en_i = en;
    any_pix = 1'b1;
    model(one, fs, en, cyc + 1);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    pix_vld_i = 1'b0;
    fsync_i = 1'b0;
    pix_i = 8'h5A;
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  always @(negedge clk_i) if (mon_on) begin
    if (exp_code.exists(cyc)) begin
      chk(code_vld_o === 1'b1, exp_req[cyc], int'(code_vld_o), 1);
      chk(code_o === exp_code[cyc], "R2", int'(code_o), int'(exp_code[cyc]));
      chk(fsync_o === exp_fs[cyc], "R6", int'(fsync_o), int'(exp_fs[cyc]));
    end else begin
      chk(code_vld_o === 1'b0, any_pix ? "R10" : "R1", int'(code_vld_o), 0);
      chk(fsync_o === 1'b0, "R6", int'(fsync_o), 0);
    end
  end

  task automatic t_reset;
    scen = "R1 reset";
    idle(3);
    chk(code_vld_o === 1'b0, "R1", int'(code_vld_o), 0);
    chk(fsync_o === 1'b0, "R1", int'(fsync_o), 0);
    chk(code_o === 8'h00, "R1", int'(code_o), 0);
  endtask

  task automatic t_pre_frame;
    scen = "R8 before first frame";
    px(1, 0, 1);
    px(0, 0, 1);
    idle(3);
  endtask

  task automatic t_alternate;
    scen = "R3 alternating";
    px(1, 1, 1);
    for (int i = 0; i < 6; i++) px(i % 2 == 1, 0, 1);
  endtask

  task automatic t_long_runs;
    scen = "R4 runs 127 128 129";
    px(0, 1, 1);
    for (int i = 1; i < 127; i++) px(0, 0, 1);
    for (int i = 0; i < 128; i++) px(1, 0, 1);
    for (int i = 0; i < 129; i++) px(0, 0, 1);
  endtask

  task automatic t_gaps;
    scen = "R9 idle gaps";
    px(1, 1, 1);
    idle(3);
    px(1, 0, 1);
    idle(2);
    px(1, 0, 1);
    px(0, 0, 1);
    idle(4);
  endtask

  task automatic t_short_frames;
    scen = "R5 single-pixel frames";
    px(1, 1, 1);
    px(1, 1, 1);
    px(1, 1, 1);
    px(0, 1, 1);
    idle(2);
  endtask

  task automatic t_transparent;
    scen = "R7 R8 transparent and mode change";
    px(1, 1, 0);
    px(0, 0, 1);
    px(1, 0, 0);
    px(0, 1, 1);
    px(0, 0, 0);
    px(1, 0, 1);
    px(1, 1, 1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    mon_on = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_pre_frame();
    t_alternate();
    t_long_runs();
    t_gaps();
    t_short_frames();
    t_transparent();
    scen = "R5 final flush";
    px(0, 1, 1);
    idle(6);
    finish_run();
  end
endmodule